// File: doc/BRIEF.md
# Power-on reset sequencer

This block turns an external active-low reset pin into the internal core reset. The pin only counts when a second input, the pull-down status, is also low. When both are low, the block enters its reset state at once, with no clock edge needed. In that state the core reset is high, the active-low reset output is low, a request goes out to abort bus cycles, drop holds and tristate the drivers, and pull-ups are enabled on the configuration port.

Release depends on a boot strap, which is captured while the filtered reset is held. A low strap selects external memory. The core then starts a fixed number of clocks after the pin rises, and that number is set by a parameter. A high strap selects internal memory. The core then stays in reset until the flash initializer raises its ready handshake. Releasing reset is synchronous to the clock. Asserting it is not.

Top module: `rst_seq`

## Requirements
- R1: A reset is recognised only while `rst_ni` and `pulldown_ni` are both low. While `pulldown_ni` is high, a low `rst_ni` leaves a running core running.
- R2: Recognition asserts all four reset outputs combinationally, with no clock edge, including while the clock is stopped.
- R3: During reset `core_rst_o`=1, `rst_out_no`=0, `bus_abort_o`=1 and `cfg_pullup_o`=1. All four change back in the same cycle.
- R4: Release passes through a two-stage synchroniser. The filtered reset goes inactive at the second rising clock edge after the pin rises.
- R5: With the strap low (external boot), `core_rst_o` falls at rising edge number 2+`REL_CYC` after `rst_ni` rises. `flash_ready_i` has no effect in this mode.
- R6: With the strap high (internal boot), `core_rst_o` falls at the first rising edge, counting from the third edge after the pin rises, at which `flash_ready_i` is sampled high. While `flash_ready_i` stays low, `core_rst_o` stays high.
- R7: The strap is captured at the edge where the filtered reset goes inactive. Changes to the strap after that edge have no effect until the next recognised reset.
- R8: `REL_CYC` lies in the range 3 to 8 and is counted by a 3-bit down-counter that stops at zero. Once released, the core stays out of reset until the next recognised reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | External reset pin, active low |
| pulldown_ni | input | 1 | Pull-down status; low qualifies the reset pin |
| boot_strap_i | input | 1 | Boot source: 0 external memory, 1 internal memory |
| flash_ready_i | input | 1 | Flash initialization done |
| core_rst_o | output | 1 | Internal core reset, active high |
| rst_out_no | output | 1 | Reset output pin, active low |
| bus_abort_o | output | 1 | Abort bus cycles, cancel holds, tristate drivers |
| cfg_pullup_o | output | 1 | Enable pull-ups on the configuration port |

## Verification
The bench builds two copies side by side on shared inputs. One has `REL_CYC`=3, the smallest delay. The other has `REL_CYC`=8, where the 3-bit counter starts from its highest loaded value. Both delay limits are therefore checked against the same pin edge. In internal boot mode the two copies must agree, because the delay parameter must not matter there. Randomly timed ready pulses fall both before and after the third edge, which covers early and late handshakes.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int unsigned CNT_W = 3;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    RS_HOLD  = 2'd0,
    RS_DELAY = 2'd1,
    RS_FLASH = 2'd2,
    RS_RUN   = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rst_seq_sync.sv
// Async assert, synchronous release of the qualified reset.
module rst_seq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rel_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rel_no = sync_q[STAGES-1];
endmodule

// File: rtl/rst_seq_strap.sv
// Strap tracks the pin while held; frozen from the release edge on.
module rst_seq_strap (
  input  logic clk_i,
  input  logic hold_i,
  input  logic strap_i,
  output logic boot_int_o
);
  logic strap_q;

  always_ff @(posedge clk_i) begin
    if (hold_i) strap_q <= strap_i;
  end

  assign boot_int_o = strap_q;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int unsigned REL_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rel_ni,
  input  logic             boot_int_i,
  input  logic             flash_ready_i,
  output rs_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(REL_CYC - 2);

  rs_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      RS_HOLD: begin
        if (!boot_int_i)        state_d = RS_DELAY;
        else if (flash_ready_i) state_d = RS_RUN;
        else                    state_d = RS_FLASH;
      end
      RS_DELAY: begin
        if (cnt_q == '0) state_d = RS_RUN;
        else             cnt_d   = cnt_q - 1'b1;
      end
      RS_FLASH: if (flash_ready_i) state_d = RS_RUN;
      RS_RUN:   ;
      default:  state_d = RS_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rel_ni) begin
    if (!rel_ni) begin
      state_q <= RS_HOLD;
      cnt_q   <= CNT_INIT;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rst_seq.sv
module rst_seq
  import rst_seq_pkg::*;
#(
  parameter int unsigned REL_CYC = 4  // 3..8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulldown_ni,
  input  logic boot_strap_i,
  input  logic flash_ready_i,
  output logic core_rst_o,
  output logic rst_out_no,
  output logic bus_abort_o,
  output logic cfg_pullup_o
);
  logic             arst_n;
  logic             rel_n;
  logic             boot_int;
  rs_state_e        state;
  logic [CNT_W-1:0] dly_cnt;
  logic             run;

  assign arst_n = rst_ni | pulldown_ni;

  rst_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .arst_ni(arst_n),
    .rel_no (rel_n)
  );

  rst_seq_strap u_strap (
    .clk_i     (clk_i),
    .hold_i    (~rel_n),
    .strap_i   (boot_strap_i),
    .boot_int_o(boot_int)
  );

  rst_seq_ctrl #(.REL_CYC(REL_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rel_ni       (rel_n),
    .boot_int_i   (boot_int),
    .flash_ready_i(flash_ready_i),
    .state_o      (state),
    .cnt_o        (dly_cnt)
  );

  assign run          = (state == RS_RUN);
  assign core_rst_o   = ~run;
  assign rst_out_no   = run;
  assign bus_abort_o  = ~run;
  assign cfg_pullup_o = ~run;
endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk
  import rst_seq_pkg::*;
#(
  parameter int unsigned REL_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pulldown_ni,
  input logic             flash_ready_i,
  input logic             core_rst_o,
  input logic             rel_n,
  input logic             boot_int,
  input rs_state_e        state,
  input logic [CNT_W-1:0] dly_cnt
);
  logic qual_n;
  assign qual_n = rst_ni | pulldown_ni;

  AST_FLASH_WAIT: assert property (@(posedge clk_i) disable iff (!qual_n)
    (core_rst_o && boot_int && !flash_ready_i) |=> core_rst_o); // R6

  AST_STAY_RUN: assert property (@(posedge clk_i) disable iff (!qual_n)
    !core_rst_o |=> !core_rst_o); // R8

  AST_STRAP_HELD: assert property (@(posedge clk_i) disable iff (!qual_n)
    (rel_n && $past(rel_n)) |-> $stable(boot_int)); // R7

  AST_DELAY_HOLD: assert property (@(posedge clk_i) disable iff (!qual_n)
    (state == RS_DELAY && dly_cnt != '0) |=> core_rst_o); // R5

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!qual_n)
    32'(dly_cnt) <= REL_CYC - 2); // R8

  AST_HELD_IN_SYNC: assert property (@(posedge clk_i) disable iff (!qual_n)
    !rel_n |-> core_rst_o); // R4
endmodule

bind rst_seq rst_seq_chk #(.REL_CYC(REL_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pulldown_ni  (pulldown_ni),
  .flash_ready_i(flash_ready_i),
  .core_rst_o   (core_rst_o),
  .rel_n        (rel_n),
  .boot_int     (boot_int),
  .state        (state),
  .dly_cnt      (dly_cnt)
);

// File: tb/rst_seq_test.sv
module rst_seq_test;
  localparam int unsigned REL_A = 3;
  localparam int unsigned REL_B = 8;

  logic clk = 1'b0;
  logic clk_en = 1'b1;
  logic rst_ni = 1'b0;
  logic pulldown_ni = 1'b0;
  logic boot_strap_i = 1'b0;
  logic flash_ready_i = 1'b0;
  logic c0, rn0, ba0, pu0;
  logic c1, rn1, ba1, pu1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always begin
    #5;
    if (clk_en) clk = ~clk;
  end

  rst_seq #(.REL_CYC(REL_A)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pulldown_ni(pulldown_ni),
    .boot_strap_i(boot_strap_i), .flash_ready_i(flash_ready_i),
    .core_rst_o(c0), .rst_out_no(rn0), .bus_abort_o(ba0), .cfg_pullup_o(pu0)
  );

  rst_seq #(.REL_CYC(REL_B)) uut_max (
    .clk_i(clk), .rst_ni(rst_ni), .pulldown_ni(pulldown_ni),
    .boot_strap_i(boot_strap_i), .flash_ready_i(flash_ready_i),
    .core_rst_o(c1), .rst_out_no(rn1), .bus_abort_o(ba1), .cfg_pullup_o(pu1)
  );

  function automatic int exp_edge(input bit strap, input int rel, input int d);
    if (!strap) return 2 + rel;         // R5
    return (d + 1 > 3) ? d + 1 : 3;     // R6
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit outs_in_reset();
    return c0 && !rn0 && ba0 && pu0 && c1 && !rn1 && ba1 && pu1;
  endfunction

  function automatic bit outs_coherent();
    return (rn0 == !c0) && (ba0 == c0) && (pu0 == c0) &&
           (rn1 == !c1) && (ba1 == c1) && (pu1 == c1);
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // one reset/release cycle; edge numbers counted from the pin rise
  task automatic trial(input bit strap, input int d, input bit flip);
    int e0 = 0;
    int e1 = 0;
    int incoh = 0;
    int hold;
    @(negedge clk);
    pulldown_ni   = 1'b0;
    rst_ni        = 1'b0;
    flash_ready_i = 1'b0;
    boot_strap_i  = strap;
    #1;
    check(outs_in_reset(), "R3 reset state", int'(c0), 1);
    hold = 2 + int'($urandom % 5);
    repeat (hold) @(negedge clk);
    if (d == 0) flash_ready_i = 1'b1;
    rst_ni = 1'b1;
    for (int j = 1; j <= 30; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (!outs_coherent()) incoh++;
      if (!c0 && e0 == 0) e0 = j;
      if (!c1 && e1 == 0) e1 = j;
      if (j == d) flash_ready_i = 1'b1;
      if (flip && j == 2) boot_strap_i = ~strap;  // after capture edge, R7
    end
    check(e0 == exp_edge(strap, REL_A, d),
          strap ? "R6 release uut" : (flip ? "R7 release uut" : "R5 release uut"),
          e0, exp_edge(strap, REL_A, d));
    check(e1 == exp_edge(strap, REL_B, d),
          strap ? "R6 release uut_max" : (flip ? "R7 release uut_max" : "R5 release uut_max"),
          e1, exp_edge(strap, REL_B, d));
    check(incoh == 0, "R3 outputs move together", incoh, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int unused_seed;
    int stuck;
    unused_seed = $urandom(32'd2024);
    #1;
    check(outs_in_reset(), "R2 reset at time zero", int'(c0), 1);

    // directed: external boot, ready held high (ignored), R4/R5 minimal path
    trial(1'b0, 0, 1'b0);
    // directed: internal boot, ready early and late
    trial(1'b1, 0, 1'b0);
    trial(1'b1, 2, 1'b0);
    trial(1'b1, 3, 1'b0);
    trial(1'b1, 17, 1'b0);
    // directed: strap flipped after capture
    trial(1'b0, 5, 1'b1);
    trial(1'b1, 9, 1'b1);

    // R8 strap toggling after release has no effect
    @(negedge clk);
    boot_strap_i = ~boot_strap_i;
    flash_ready_i = 1'b0;
    repeat (4) @(negedge clk);
    check(!c0 && !c1 && rn0 && rn1, "R8 stays released", int'(c0), 0);

    // R1 pin low without pull-down qualification is ignored
    pulldown_ni = 1'b1;
    rst_ni = 1'b0;
    stuck = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (c0 || c1 || !rn0 || ba0 || pu0) stuck++;
    end
    check(stuck == 0, "R1 unqualified pin ignored", stuck, 0);
    #2;
    pulldown_ni = 1'b0;
    #1;
    check(outs_in_reset(), "R1 qualification asserts reset", int'(c0), 1);

    // R2 recognition with the clock stopped
    @(negedge clk);
    rst_ni = 1'b1;
    pulldown_ni = 1'b0;
    boot_strap_i = 1'b0;
    repeat (14) @(negedge clk);
    check(!c0 && !c1, "R5 running before stop", int'(c1), 0);
    clk_en = 1'b0;
    #20;
    rst_ni = 1'b0;
    #2;
    check(outs_in_reset(), "R2 async assert without clock", int'(c0), 1);
    #20;
    clk_en = 1'b1;

    // random mix
    for (int t = 0; t < 24; t++) begin
      trial(1'($urandom % 2), int'($urandom % 21), 1'($urandom % 2));
    end

    done = 1'b1;
    finish_run();
  end
endmodule